// File: doc/BRIEF.md
# Watchdog Timer with Seconds/Minutes Time Base

This block is the watchdog of a peripheral controller's runtime register space. Software writes an 8-bit timeout and chooses whether that timeout counts seconds or minutes. The block receives a one-cycle pulse once per second from elsewhere in the chip and counts down from the programmed value. When the count reaches zero it raises a one-clock reset pulse and sets a sticky triggered flag. Software clears that flag explicitly.

Keyboard and mouse activity pulses can each be allowed to reload the timeout while the watchdog is running. The expiry pulse reaches the external watchdog pin only when the pin's function field selects the watchdog. Software reaches every setting through a byte-wide register port addressed by runtime offset. Writes are synchronous. Reads return data combinationally for the offset presented.

Top module: `wdog_runtime`

## Requirements
- R1: After reset every mapped register reads 0: the unit is minutes, the watchdog is stopped, both reloads are disabled, the flag is clear and the pin function is 0. `rst_pulse` and `wdt_pin` are low.
- R2: Writing a nonzero value N to offset 0x66 loads the counter with N and starts it. Reading offset 0x66 returns the remaining count. In seconds mode the count drops by one on each `tick_sec` pulse, and it never rises except on a write or a reload.
- R3: Bit 7 of offset 0x65 selects the unit: 1 means seconds and 0 means minutes. In minutes mode the count drops once every 60 `tick_sec` pulses. The 60-tick prescaler restarts on every write to offset 0x66.
- R4: Writing 0 to offset 0x66 stops the watchdog. A stopped counter stays at 0 and produces no expiry.
- R5: When a time-unit step moves the count from 1 to 0, `rst_pulse` goes high for exactly one clock. The counter then stays at 0 until offset 0x66 is written again.
- R6: Bit 0 of offset 0x68 is the triggered flag. It is set at expiry and stays set. A write to offset 0x68 with bit 0 = 0 clears it, and a write with bit 0 = 1 has no effect. If an expiry and a clear happen in the same cycle, the flag ends up set.
- R7: Bit 1 of offset 0x67 enables `kbd_act` to reload the last written timeout, and bit 2 enables `mse_act` to do the same. A reload also restarts the prescaler. A disabled source has no effect, and no source reloads a counter that is at 0.
- R8: Offset 0x47 holds an 8-bit pin-function byte and reads back all 8 bits. `wdt_pin` carries the expiry pulse only when bits [3:0] equal 0xE; otherwise it stays low.
- R9: A write to an unmapped offset changes no register, and a read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Runtime register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tick_sec | input | 1 | One-cycle pulse once per second |
| kbd_act | input | 1 | Keyboard activity pulse |
| mse_act | input | 1 | Mouse activity pulse |
| wdt_pin | output | 1 | Watchdog pin, gated by the pin-function field |
| rst_pulse | output | 1 | One-clock reset pulse at expiry |

## Verification
The assertions check four things on every cycle:
- the expiry pulse never lasts longer than one clock, and appears only when the count has just stepped from 1 to 0;
- the triggered flag rises only together with that pulse and falls only on a clearing write;
- a stopped counter stays at 0 and a running count never climbs without a load;
- the pin never shows activity that is not an expiry.

Some behaviour depends on software setup and on counting ticks, so only the bench scenarios can show it:
- the exact number of ticks per minute step and the prescaler restart;
- which activity source reloads under which enable bits;
- the rule that a same-cycle expiry beats a clear;
- the readback of each register.

// File: rtl/wdog_pkg.sv
// Package: shared offsets, bit positions and codes for the runtime watchdog.
// Assumes an 8-bit runtime offset space; offsets are widened where used.
package wdog_pkg;
    localparam logic [7:0] OFF_PINFN = 8'h47;
    localparam logic [7:0] OFF_UNIT  = 8'h65;
    localparam logic [7:0] OFF_COUNT = 8'h66;
    localparam logic [7:0] OFF_CFG   = 8'h67;
    localparam logic [7:0] OFF_STAT  = 8'h68;

    localparam int UNIT_BIT   = 7;  // 1 = seconds, 0 = minutes
    localparam int ACT_LSB    = 1;  // first activity-enable bit (keyboard)
    localparam int TRIG_BIT   = 0;  // sticky triggered flag

    localparam logic [3:0] PINFN_WDT = 4'hE;
endpackage

// File: rtl/wdog_regs.sv
// Module: runtime register file of the watchdog.
// Holds the unit, activity-enable and pin-function settings, decodes the
// count and status write strokes, and forms combinational read data.
// Assumes reg_wr is a single-cycle strobe qualified by reg_addr.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int NUM_ACT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic              trig_flag,
    output logic [DATA_W-1:0] rdata,
    output logic              unit_sec,
    output logic [NUM_ACT-1:0] act_en,
    output logic [DATA_W-1:0] pinfn,
    output logic              cnt_wr,
    output logic              stat_clr
);
    localparam logic [ADDR_W-1:0] A_PINFN = ADDR_W'(OFF_PINFN);
    localparam logic [ADDR_W-1:0] A_UNIT  = ADDR_W'(OFF_UNIT);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);

    // Decode strokes that other blocks act on.
    assign cnt_wr   = wr_en && (addr == A_COUNT);
    assign stat_clr = wr_en && (addr == A_STAT) && !wdata[TRIG_BIT];

    // Store the settings registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_sec <= 1'b0;
            act_en   <= '0;
            pinfn    <= '0;
        end else if (wr_en) begin
            if (addr == A_UNIT)  unit_sec <= wdata[UNIT_BIT];
            if (addr == A_PINFN) pinfn    <= wdata;
            if (addr == A_CFG) begin
                for (int i = 0; i < NUM_ACT; i++) begin
                    act_en[i] <= wdata[ACT_LSB + i];
                end
            end
        end
    end

    // Select read data for the presented offset.
    always_comb begin
        rdata = '0;
        if (addr == A_PINFN) begin
            rdata = pinfn;
        end else if (addr == A_UNIT) begin
            rdata[UNIT_BIT] = unit_sec;
        end else if (addr == A_COUNT) begin
            rdata = cnt_val;
        end else if (addr == A_CFG) begin
            for (int i = 0; i < NUM_ACT; i++) begin
                rdata[ACT_LSB + i] = act_en[i];
            end
        end else if (addr == A_STAT) begin
            rdata[TRIG_BIT] = trig_flag;
        end
    end
endmodule

// File: rtl/wdog_prescale.sv
// Module: time-unit step generator.
// Passes each second tick through in seconds mode. In minutes mode it emits
// one step per MIN_DIV ticks. A restart returns the prescaler to the start
// of a minute. Assumes sec_tick is a single-cycle pulse.
module wdog_prescale #(
    parameter int MIN_DIV = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic unit_sec,
    input  logic restart,
    output logic unit_tick
);
    generate
        if (MIN_DIV < 2) begin : g_direct
            assign unit_tick = sec_tick;
        end else begin : g_divide
            localparam int PW = $clog2(MIN_DIV);
            logic [PW-1:0] pre_q;
            logic          wrap;

            assign wrap = (pre_q == PW'(MIN_DIV - 1));

            // Count seconds within the current minute.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (restart) begin
                    pre_q <= '0;
                end else if (sec_tick) begin
                    pre_q <= wrap ? '0 : pre_q + 1'b1;
                end
            end

            assign unit_tick = sec_tick && (unit_sec || wrap);
        end
    endgenerate
endmodule

// File: rtl/wdog_counter.sv
// Module: watchdog down-counter with activity reload and expiry flagging.
// Priority order: a count write, then an activity reload, then a unit step.
// An expiry in the same cycle as a clear leaves the flag set. Assumes all
// activity inputs are synchronous single-cycle pulses.
module wdog_counter #(
    parameter int DATA_W  = 8,
    parameter int NUM_ACT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               unit_tick,
    input  logic [NUM_ACT-1:0] act_pulse,
    input  logic [NUM_ACT-1:0] act_en,
    input  logic               stat_clr,
    output logic [DATA_W-1:0]  cnt_q,
    output logic               trig_q,
    output logic               expire_q,
    output logic               reload,
    output logic               restart
);
    logic [DATA_W-1:0] last_q;
    logic              running;
    logic              expire_now;

    assign running    = (cnt_q != '0);
    assign reload     = running && |(act_pulse & act_en);
    assign restart    = cnt_wr || reload;
    assign expire_now = !restart && unit_tick && (cnt_q == DATA_W'(1));

    // Load, reload or step the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else if (cnt_wr) begin
            cnt_q  <= wdata;
            last_q <= wdata;
        end else if (reload) begin
            cnt_q <= last_q;
        end else if (unit_tick && running) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Register the one-clock expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) expire_q <= 1'b0;
        else        expire_q <= expire_now;
    end

    // Keep the sticky triggered flag; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          trig_q <= 1'b0;
        else if (expire_now) trig_q <= 1'b1;
        else if (stat_clr)   trig_q <= 1'b0;
    end
endmodule

// File: rtl/wdog_runtime.sv
// Module: top of the runtime watchdog.
// Joins the register file, the time-unit prescaler and the down-counter,
// and gates the expiry pulse onto the pin when the pin-function field
// selects the watchdog. Assumes tick_sec comes from a free-running source.
module wdog_runtime
    import wdog_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int MIN_DIV = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_sec,
    input  logic              kbd_act,
    input  logic              mse_act,
    output logic              wdt_pin,
    output logic              rst_pulse
);
    localparam int NUM_ACT = 2;

    logic               unit_sec;
    logic [NUM_ACT-1:0] act_en;
    logic [DATA_W-1:0]  pinfn;
    logic               cnt_wr;
    logic               stat_clr;
    logic [DATA_W-1:0]  cnt_q;
    logic               trig_q;
    logic               expire_q;
    logic               reload_evt;
    logic               restart;
    logic               unit_tick;
    logic [NUM_ACT-1:0] act_vec;

    assign act_vec = {mse_act, kbd_act};

    wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ACT(NUM_ACT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .cnt_val(cnt_q), .trig_flag(trig_q),
        .rdata(reg_rdata), .unit_sec(unit_sec), .act_en(act_en),
        .pinfn(pinfn), .cnt_wr(cnt_wr), .stat_clr(stat_clr)
    );

    wdog_prescale #(.MIN_DIV(MIN_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .sec_tick(tick_sec), .unit_sec(unit_sec),
        .restart(restart), .unit_tick(unit_tick)
    );

    wdog_counter #(.DATA_W(DATA_W), .NUM_ACT(NUM_ACT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .wdata(reg_wdata),
        .unit_tick(unit_tick), .act_pulse(act_vec), .act_en(act_en),
        .stat_clr(stat_clr), .cnt_q(cnt_q), .trig_q(trig_q),
        .expire_q(expire_q), .reload(reload_evt), .restart(restart)
    );

    assign rst_pulse = expire_q;
    assign wdt_pin   = expire_q && (pinfn[3:0] == PINFN_WDT);
endmodule

// File: rtl/wdog_runtime_chk.sv
// Module: property checker for the runtime watchdog, bound to the top.
module wdog_runtime_chk
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              rst_pulse,
    input logic              wdt_pin,
    input logic [DATA_W-1:0] cnt_q,
    input logic              trig_q,
    input logic              cnt_wr,
    input logic              reload_evt
);
    logic clr_wr;
    assign clr_wr = reg_wr && (reg_addr == ADDR_W'(OFF_STAT)) && !reg_wdata[TRIG_BIT];

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    assert_pulse_from_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> (cnt_q == '0 && $past(cnt_q) == DATA_W'(1)));

    assert_trig_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_q) |-> rst_pulse);

    assert_trig_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && !clr_wr) |=> trig_q);

    assert_stopped_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !cnt_wr) |=> cnt_q == '0);

    assert_no_climb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !reload_evt) |=> cnt_q <= $past(cnt_q));

    assert_pin_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_pin |-> rst_pulse);
endmodule

bind wdog_runtime wdog_runtime_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rst_pulse(rst_pulse), .wdt_pin(wdt_pin),
    .cnt_q(cnt_q), .trig_q(trig_q), .cnt_wr(cnt_wr), .reload_evt(reload_evt)
);

// File: tb/wdog_runtime_tb.sv
// Directed bench for the runtime watchdog: one task per scenario.
module wdog_runtime_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tick_sec = 1'b0;
    logic       kbd_act = 1'b0;
    logic       mse_act = 1'b0;
    logic       wdt_pin;
    logic       rst_pulse;

    int checks = 0;
    int failures = 0;
    int npulse = 0;
    bit done = 1'b0;
    logic [7:0] rv;

    always #2 clk = ~clk;  // 250 MHz

    wdog_runtime u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_sec(tick_sec),
        .kbd_act(kbd_act), .mse_act(mse_act), .wdt_pin(wdt_pin),
        .rst_pulse(rst_pulse)
    );

    always @(posedge clk) if (rst_n && rst_pulse) npulse++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_sec = 1'b1;
            @(negedge clk); tick_sec = 1'b0;
        end
    endtask

    task automatic act(input bit kb, input bit ms);
        @(negedge clk); kbd_act = kb; mse_act = ms;
        @(negedge clk); kbd_act = 1'b0; mse_act = 1'b0;
    endtask

    task automatic t_reset();
        rd(8'h47, rv); chk("R1 pinfn", rv, 0);
        rd(8'h65, rv); chk("R1 unit", rv, 0);
        rd(8'h66, rv); chk("R1 count", rv, 0);
        rd(8'h67, rv); chk("R1 cfg", rv, 0);
        rd(8'h68, rv); chk("R1 stat", rv, 0);
        chk("R1 rst_pulse", rst_pulse, 0);
        chk("R1 wdt_pin", wdt_pin, 0);
    endtask

    task automatic t_seconds();
        wr(8'h65, 8'h80);
        rd(8'h65, rv); chk("R3 unit readback", rv, 8'h80);
        wr(8'h66, 8'd10);
        rd(8'h66, rv); chk("R2 loaded", rv, 10);
        ticks(3);
        rd(8'h66, rv); chk("R2 after 3 ticks", rv, 7);
        wr(8'h66, 8'd0);
    endtask

    task automatic t_minutes();
        wr(8'h65, 8'h00);
        wr(8'h66, 8'd2);
        ticks(59);
        rd(8'h66, rv); chk("R3 59 ticks no step", rv, 2);
        ticks(1);
        rd(8'h66, rv); chk("R3 60th tick steps", rv, 1);
        ticks(30);
        wr(8'h66, 8'd3);
        ticks(59);
        rd(8'h66, rv); chk("R3 prescaler restart", rv, 3);
        ticks(1);
        rd(8'h66, rv); chk("R3 step after restart", rv, 2);
        wr(8'h66, 8'd0);
    endtask

    task automatic t_stop();
        int p0;
        wr(8'h65, 8'h80);
        wr(8'h66, 8'd3);
        ticks(1);
        wr(8'h66, 8'd0);
        p0 = npulse;
        ticks(5);
        rd(8'h66, rv); chk("R4 stopped count", rv, 0);
        chk("R4 no expiry", npulse, p0);
    endtask

    task automatic t_expiry();
        int p0;
        wr(8'h65, 8'h80);
        wr(8'h66, 8'd2);
        p0 = npulse;
        ticks(1);
        chk("R5 no pulse at 2->1", rst_pulse, 0);
        ticks(1);
        chk("R5 pulse at 1->0", rst_pulse, 1);
        @(negedge clk);
        chk("R5 pulse one clock", rst_pulse, 0);
        ticks(3);
        rd(8'h66, rv); chk("R5 count held at 0", rv, 0);
        chk("R5 single pulse", npulse, p0 + 1);
        rd(8'h68, rv); chk("R6 flag set", rv, 1);
    endtask

    task automatic t_sticky();
        wr(8'h68, 8'h01);
        rd(8'h68, rv); chk("R6 write 1 no effect", rv, 1);
        wr(8'h68, 8'hFE);
        rd(8'h68, rv); chk("R6 cleared", rv, 0);
        wr(8'h68, 8'h01);
        rd(8'h68, rv); chk("R6 write 1 does not set", rv, 0);
        wr(8'h66, 8'd1);
        @(negedge clk);
        tick_sec = 1'b1; reg_wr = 1'b1; reg_addr = 8'h68; reg_wdata = 8'h00;
        @(negedge clk);
        tick_sec = 1'b0; reg_wr = 1'b0;
        rd(8'h68, rv); chk("R6 set beats clear", rv, 1);
        wr(8'h68, 8'h00);
    endtask

    task automatic t_reload();
        wr(8'h65, 8'h80);
        wr(8'h67, 8'h02);
        rd(8'h67, rv); chk("R7 cfg readback", rv, 8'h02);
        wr(8'h66, 8'd5);
        ticks(3);
        act(1'b1, 1'b0);
        rd(8'h66, rv); chk("R7 kbd reload", rv, 5);
        ticks(1);
        act(1'b0, 1'b1);
        rd(8'h66, rv); chk("R7 mouse disabled", rv, 4);
        wr(8'h67, 8'h04);
        act(1'b1, 1'b0);
        rd(8'h66, rv); chk("R7 kbd disabled", rv, 4);
        act(1'b0, 1'b1);
        rd(8'h66, rv); chk("R7 mouse reload", rv, 5);
        wr(8'h67, 8'h06);
        wr(8'h66, 8'd1);
        ticks(1);
        act(1'b1, 1'b1);
        rd(8'h66, rv); chk("R7 no reload after expiry", rv, 0);
        wr(8'h67, 8'h00);
        wr(8'h68, 8'h00);
    endtask

    task automatic t_pin();
        wr(8'h65, 8'h80);
        wr(8'h47, 8'hAE);
        rd(8'h47, rv); chk("R8 pinfn readback", rv, 8'hAE);
        wr(8'h66, 8'd1);
        ticks(1);
        chk("R8 pin selected", wdt_pin, 1);
        wr(8'h47, 8'h0D);
        wr(8'h66, 8'd1);
        ticks(1);
        chk("R8 pulse present", rst_pulse, 1);
        chk("R8 pin not selected", wdt_pin, 0);
        wr(8'h68, 8'h00);
    endtask

    task automatic t_unmapped();
        wr(8'h66, 8'd9);
        wr(8'h50, 8'hFF);
        rd(8'h50, rv); chk("R9 unmapped reads 0", rv, 0);
        rd(8'h66, rv); chk("R9 count untouched", rv, 9);
        rd(8'h47, rv); chk("R9 pinfn untouched", rv, 8'h0D);
        rd(8'h67, rv); chk("R9 cfg untouched", rv, 0);
        wr(8'h66, 8'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seconds();
        t_minutes();
        t_stop();
        t_expiry();
        t_sticky();
        t_reload();
        t_pin();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule